// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the arithmetic and logic stage that sits behind the accumulator of a wide datapath. Each cycle it takes the accumulator value, a second operand, the incoming carry flag and a 4-bit operation code. One clock later it returns a result word, the four condition flags N, V, Z and C, and a mask that says which of those flags the operation is allowed to update. The caller merges the flags into its status register under that mask. A write-back strobe tells the caller whether the result is meant to replace the accumulator.

The block covers add and subtract with carry, the three bitwise logic operations, shifts and rotates by a count taken from the operand, arithmetic shift right, compare and multiply. Division is present only as a stub. That stub reports a zero divisor and leaves the quotient to a separate multi-cycle unit. The word width is the parameter `W`, which defaults to 64.

Top module: `acc_alu`

## Requirements
- R1: Op code 0 (add) returns acc + opd + carry_i modulo 2^W. C is the carry out of the top bit. V is set when the signed sum overflows. N and Z follow the result, and the mask is 4'b1111.
- R2: Op code 1 (subtract) returns acc - opd - (1 - carry_i) modulo 2^W, so carry_i = 1 means no borrow. C is 1 when no borrow occurs. V is set on signed overflow, N and Z follow the result, and the mask is 4'b1111.
- R3: Op codes 2, 3 and 4 return acc AND, OR and XOR opd. They set the mask to 4'b1010, so only N and Z may change.
- R4: Op codes 5 and 6 shift acc left and right (zero fill) by opd modulo W. C is 1 when any 1 bit leaves the word, and the mask is 4'b1011.
- R5: Op codes 7 and 8 rotate acc left and right by opd modulo W. C is 1 when any 1 bit crosses the word edge, and the mask is 4'b1011.
- R6: Op code 9 shifts acc right by opd modulo W, filling the vacated bits with the sign bit. C is 1 when any 1 bit leaves the word, and the mask is 4'b1011.
- R7: For op codes 5 to 9, a count of 0 (modulo W) returns acc unchanged with C = 0.
- R8: Op code 11 (multiply) returns the low W bits of acc*opd + carry_i. V and C are both 1 when that full value does not fit in W bits, and the mask is 4'b1111.
- R9: Op code 10 (compare) computes acc - opd and sets N, V, Z and C as a subtract with no incoming borrow would. It sets the mask to 4'b1111, drives wb_o low and returns acc unchanged on result_o.
- R10: Op code 12 (divide stub) returns zero with wb_o low and the mask 4'b1110. V and div_zero_o are 1 exactly when opd is zero. N is 0 and Z is 1.
- R11: The flags are packed as {N,V,Z,C} in bits [3:0]. Any flag bit outside the mask reads 0. wb_o is high for op codes 0 to 9 and 11. Op codes 13 to 15 return zero with the mask 0 and wb_o low.
- R12: All outputs are registered and appear one clock after the inputs. While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| acc_i | input | W | Accumulator value |
| opd_i | input | W | Second operand (memory or B register) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | W | Result word |
| flags_o | output | 4 | New flags {N,V,Z,C}, masked |
| mask_o | output | 4 | Flags the operation may update |
| wb_o | output | 1 | Result should be written to the accumulator |
| div_zero_o | output | 1 | Divide with a zero divisor |

## Verification
Every result, flag, mask and strobe is due exactly one clock edge after the operands are presented, because a single output register follows the combinational datapath. The bench drives each vector on a falling edge and compares all outputs on the next falling edge. That comparison point lies after the one rising edge that captures the vector and before any later one. The sweep runs an 8-bit instance over every op code, both carry values and a grid of operand pairs. This grid covers every shift count modulo the width and the sign and overflow corners.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opd_i,
  input  logic         carry_i,
  output logic [W-1:0] result_o,
  output logic [3:0]   flags_o,
  output logic [3:0]   mask_o,
  output logic         wb_o,
  output logic         div_zero_o
);
  localparam int CW = $clog2(W);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
                         OP_XOR = 4'd4, OP_SHL = 4'd5, OP_SHR = 4'd6, OP_ROL = 4'd7,
                         OP_ROR = 4'd8, OP_ASR = 4'd9, OP_CMP = 4'd10, OP_MUL = 4'd11,
                         OP_DIV = 4'd12;

  logic [CW-1:0]   cnt;
  logic [W:0]      add_s, sub_s, cmp_s;
  logic [2*W-1:0]  shl_w, shr_w, prod;
  logic signed [W-1:0] asr_s;
  logic [W-1:0]    res, fsrc;
  logic            v, c, wb, dz;
  logic [3:0]      mask;

  assign cnt   = opd_i[CW-1:0];
  assign add_s = {1'b0, acc_i} + {1'b0, opd_i} + {{W{1'b0}}, carry_i};
  assign sub_s = {1'b0, acc_i} + {1'b0, ~opd_i} + {{W{1'b0}}, carry_i};
  assign cmp_s = {1'b0, acc_i} + {1'b0, ~opd_i} + {{W{1'b0}}, 1'b1};
  assign shl_w = {{W{1'b0}}, acc_i} << cnt;
  assign shr_w = {acc_i, {W{1'b0}}} >> cnt;
  assign asr_s = $signed(acc_i) >>> cnt;
  assign prod  = ({{W{1'b0}}, acc_i} * {{W{1'b0}}, opd_i}) + {{(2*W-1){1'b0}}, carry_i};

  always_comb begin
    res  = '0;
    v    = 1'b0;
    c    = 1'b0;
    wb   = 1'b1;
    dz   = 1'b0;
    mask = 4'b0000;
    case (op_i)
      OP_ADD: begin
        res  = add_s[W-1:0];
        c    = add_s[W];
        v    = (acc_i[W-1] == opd_i[W-1]) && (add_s[W-1] != acc_i[W-1]);
        mask = 4'b1111;
      end
      OP_SUB: begin
        res  = sub_s[W-1:0];
        c    = sub_s[W];
        v    = (acc_i[W-1] != opd_i[W-1]) && (sub_s[W-1] != acc_i[W-1]);
        mask = 4'b1111;
      end
      OP_AND: begin res = acc_i & opd_i; mask = 4'b1010; end
      OP_OR:  begin res = acc_i | opd_i; mask = 4'b1010; end
      OP_XOR: begin res = acc_i ^ opd_i; mask = 4'b1010; end
      OP_SHL: begin res = shl_w[W-1:0]; c = |shl_w[2*W-1:W]; mask = 4'b1011; end
      OP_SHR: begin res = shr_w[2*W-1:W]; c = |shr_w[W-1:0]; mask = 4'b1011; end
      OP_ROL: begin
        res  = shl_w[W-1:0] | shl_w[2*W-1:W];
        c    = |shl_w[2*W-1:W];
        mask = 4'b1011;
      end
      OP_ROR: begin
        res  = shr_w[2*W-1:W] | shr_w[W-1:0];
        c    = |shr_w[W-1:0];
        mask = 4'b1011;
      end
      OP_ASR: begin res = $unsigned(asr_s); c = |shr_w[W-1:0]; mask = 4'b1011; end
      OP_CMP: begin
        res  = acc_i;
        c    = cmp_s[W];
        v    = (acc_i[W-1] != opd_i[W-1]) && (cmp_s[W-1] != acc_i[W-1]);
        wb   = 1'b0;
        mask = 4'b1111;
      end
      OP_MUL: begin
        res  = prod[W-1:0];
        v    = |prod[2*W-1:W];
        c    = v;
        mask = 4'b1111;
      end
      OP_DIV: begin
        dz   = (opd_i == '0);
        v    = dz;
        wb   = 1'b0;
        mask = 4'b1110;
      end
      default: wb = 1'b0;
    endcase
  end

  assign fsrc = (op_i == OP_CMP) ? cmp_s[W-1:0] : res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o   <= '0;
      flags_o    <= '0;
      mask_o     <= '0;
      wb_o       <= 1'b0;
      div_zero_o <= 1'b0;
    end else begin
      result_o   <= res;
      flags_o    <= {fsrc[W-1], v, (fsrc == '0), c} & mask;
      mask_o     <= mask;
      wb_o       <= wb;
      div_zero_o <= dz;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opd_i,
  input logic         carry_i,
  input logic [W-1:0] result_o,
  input logic [3:0]   flags_o,
  input logic [3:0]   mask_o,
  input logic         wb_o,
  input logic         div_zero_o
);
  localparam int CW = $clog2(W);

  assert_flags_in_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & ~mask_o) == 4'b0000);

  assert_cmp_no_writeback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd10) |=> (!wb_o && result_o == $past(acc_i) && mask_o == 4'b1111));

  assert_div_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd12 && opd_i == '0) |=> (div_zero_o && flags_o[2] && result_o == '0));

  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd5 && op_i <= 4'd9 && opd_i[CW-1:0] == '0) |=>
      (result_o == $past(acc_i) && !flags_o[0]));

  assert_logic_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd2 && op_i <= 4'd4) |=> (mask_o == 4'b1010));

  assert_zero_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_o && mask_o[1]) |-> (flags_o[1] == (result_o == '0)));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opd_i(opd_i),
  .carry_i(carry_i), .result_o(result_o), .flags_o(flags_o), .mask_o(mask_o),
  .wb_o(wb_o), .div_zero_o(div_zero_o)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [W-1:0] acc_i = '0, opd_i = '0;
  logic carry_i = 1'b0;
  logic [W-1:0] result_o;
  logic [3:0] flags_o, mask_o;
  logic wb_o, div_zero_o;
  int vecs = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  acc_alu #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .opd_i(opd_i),
    .carry_i(carry_i), .result_o(result_o), .flags_o(flags_o), .mask_o(mask_o),
    .wb_o(wb_o), .div_zero_o(div_zero_o)
  );

  function automatic int sgn(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  function automatic string tag(int op);
    case (op)
      0: return "R1"; 1: return "R2"; 2, 3, 4: return "R3";
      5, 6: return "R4"; 7, 8: return "R5"; 9: return "R6";
      10: return "R9"; 11: return "R8"; 12: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input int op, input int a, input int b, input int c,
                       output int r, output int f, output int m, output int wb, output int dz);
    int n, d, sd, out, fz;
    int nf, vf, zf, cf;
    n = b % 8; r = 0; vf = 0; cf = 0; wb = 1; dz = 0; m = 0; fz = -1;
    case (op)
      0: begin d = a + b + c; r = d % 256; cf = d > 255;
               sd = sgn(a) + sgn(b) + c; vf = (sd > 127 || sd < -128); m = 15; end
      1: begin d = a - b - (1 - c); r = (d + 256) % 256; cf = d >= 0;
               sd = sgn(a) - sgn(b) - (1 - c); vf = (sd > 127 || sd < -128); m = 15; end
      2: begin r = a & b; m = 10; end
      3: begin r = a | b; m = 10; end
      4: begin r = a ^ b; m = 10; end
      5, 7: begin out = (n == 0) ? 0 : (a >> (8 - n));
                  r = (a << n) % 256; if (op == 7) r = r | out;
                  cf = out != 0; m = 11; end
      6, 8, 9: begin out = a % (1 << n); r = a >> n;
                  if (op == 8 && n != 0) r = r | ((out << (8 - n)) % 256);
                  if (op == 9 && a >= 128) r = r | ((255 << (8 - n)) % 256);
                  cf = out != 0; m = 11; end
      10: begin d = a - b; r = a; fz = (d + 256) % 256; cf = d >= 0;
                sd = sgn(a) - sgn(b); vf = (sd > 127 || sd < -128); wb = 0; m = 15; end
      11: begin d = a * b + c; r = d % 256; vf = d > 255; cf = vf; m = 15; end
      12: begin dz = (b == 0); vf = dz; wb = 0; m = 14; end
      default: begin wb = 0; m = 0; end
    endcase
    if (fz < 0) fz = r;
    nf = fz >= 128; zf = fz == 0;
    f = (nf * 8 + vf * 4 + zf * 2 + cf) & m;
  endtask

  task automatic apply(input int op, input int a, input int b, input int c);
    int er, ef, em, ew, ed;
    @(negedge clk);
    op_i = op[3:0]; acc_i = a[W-1:0]; opd_i = b[W-1:0]; carry_i = c[0];
    model(op, a, b, c, er, ef, em, ew, ed);
    @(negedge clk);
    vecs++;
    if (int'(result_o) != er || int'(flags_o) != ef || int'(mask_o) != em ||
        int'(wb_o) != ew || int'(div_zero_o) != ed) begin
      bad++;
      $display("FAIL %s op=%0d a=%0d b=%0d c=%0d: got r=%0d f=%b m=%b wb=%0d dz=%0d exp r=%0d f=%b m=%b wb=%0d dz=%0d",
               tag(op), op, a, b, c, result_o, flags_o, mask_o, wb_o, div_zero_o,
               er, ef[3:0], em[3:0], ew, ed);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vecs++;
    if (result_o != '0 || flags_o != '0 || mask_o != '0 || wb_o || div_zero_o) begin
      bad++;
      $display("FAIL R12 reset: got r=%0d f=%b m=%b wb=%0d dz=%0d exp all zero",
               result_o, flags_o, mask_o, wb_o, div_zero_o);
    end
    rst_n = 1'b1;
    // R12 one-cycle latency is exercised by every apply; R7 by counts 0 and 8
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a += 7)
          for (int b = 0; b < 256; b += 7)
            apply(op, a, b, c);
    // corner vectors: R1 R2 R4 R6 R7 R8 R10
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 2; c++) begin
        apply(op, 255, 255, c);
        apply(op, 128, 8, c);
        apply(op, 127, 1, c);
        apply(op, 128, 128, c);
        apply(op, 0, 0, c);
        apply(op, 129, 7, c);
        apply(op, 255, 16, c);
      end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule